// File: doc/BRIEF.md
# Dual-Rate Frequency Lock Monitor and Training Controller

This block supervises a clock recovery loop that can run at either of two line rates. It counts edges of a divided-down recovered clock over fixed windows of reference-clock cycles. It then decides whether the loop should be steered to the local reference (training) or left to follow the incoming data (tracking). After every reset and after every upset, the loop first spends a set number of windows in training. Only then is it released. Lock is declared once enough consecutive windows land inside the accepted band, and it is withdrawn as soon as one window falls outside.

Two active-low loss-of-signal sources are combined: a signal-detect input that is low on loss, and a force-to-reference input that is active low. Either one drops the lock flag at once, raises the data-mute enable and holds the loop in training. A test input in high-rate mode selects a bypass in which the lock logic is idle and the loop is kept on the reference. The same test input in low-rate mode is an illegal combination that is flagged.

The state machine has five states:
- TRAIN: the loop is steered to the reference.
- TRACK0: released, with no good window yet.
- TRACK1: released, with one good window.
- LOCKED: lock has been declared.
- BYPASS: the test bypass is active.

Its transitions are:
- TRAIN to TRACK0: at the window boundary that completes the training count.
- TRACK0 to TRACK1: on a good window.
- TRACK1 to LOCKED: on a second good window.
- LOCKED to LOCKED: on each further good window.
- TRACK0, TRACK1 or LOCKED to TRAIN: on any bad window.
- Any state to TRAIN: on loss of signal or illegal configuration.
- Any state to BYPASS: when bypass is selected.
- BYPASS to TRAIN: when bypass is released.

Top module: `freq_lock_ctrl`

## Requirements
- R1: While reset is held, train_ref is 1, lock is 0, and mute and bad_cfg follow only their combinational input conditions.
- R2: A window lasts 2^WIN_LOG2 reference cycles. The expected rising-edge count of the divided recovered clock is window×ratio/PRE_DIV, where the ratio is 32 when rate_hi=1 and 8 when rate_hi=0. A window is good when the count is within ± (floor(expected×TOL_PPM/10^6) + 1) of the expected value.
- R3: Training lasts TRAIN_WINS window boundaries, counted from the first boundary after training is entered or after the last hold cycle. train_ref falls at the last of those boundaries.
- R4: lock rises at the end of the second consecutive good window after release, and not after the first.
- R5: One bad window while released or locked drops lock and raises train_ref at that boundary. The training-then-release cycle then repeats for as long as windows stay bad.
- R6: When sig_det=0 or lock_ref_n=0 (without bypass), lock is 0 and mute is 1 in the same cycle, training is held, and its count restarts. Lock can return only after a full training phase and two good windows.
- R7: When test_en=1 and rate_hi=1 (bypass), train_ref=1, lock=0 and mute=0, whatever the loss-of-signal inputs are.
- R8: When test_en=1 and rate_hi=0, bad_cfg=1, and the block acts as under loss of signal (mute=1, lock=0, training held).
- R9: In low-rate mode (rate_hi=0), lock is gained and lost against the ×8 expected count.
- R10: When loss of signal and a window boundary fall in the same cycle, loss of signal wins: the state returns to training even if the window was good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_div_clk | input | 1 | Divided recovered clock, asynchronous to clk_ref |
| rate_hi | input | 1 | 1 selects the ×32 rate, 0 selects the ×8 rate |
| sig_det | input | 1 | Signal detect, active high |
| lock_ref_n | input | 1 | Force-to-reference request, active low |
| test_en | input | 1 | Test select (bypass with rate_hi=1) |
| train_ref | output | 1 | 1 steers the loop to the reference, 0 to the data |
| lock | output | 1 | Debounced frequency lock flag |
| mute | output | 1 | Serial data mute enable |
| bad_cfg | output | 1 | Illegal test/rate combination |

## Verification
The case that needs care is loss of signal arriving in the very cycle in which a window closes. In that cycle, frequency evaluation and loss-of-signal handling both try to set the next state. The bench drives sig_det low for exactly that one cycle while the block is locked on a good frequency. It then checks that the state goes back to training rather than staying locked, that training runs a full count from that boundary, and that lock comes back only after two further good windows. The behavioural model, compared on every clock, encodes the priority independently.

// File: rtl/lk_pkg.sv
package lk_pkg;
    typedef enum logic [2:0] {
        ST_TRAIN  = 3'd0,
        ST_TRACK0 = 3'd1,
        ST_TRACK1 = 3'd2,
        ST_LOCKED = 3'd3,
        ST_BYPASS = 3'd4
    } lk_state_e;
endpackage

// File: rtl/lk_win_timer.sv
module lk_win_timer #(
    parameter int WIN_LOG2 = 12
) (
    input  logic clk_ref,
    input  logic rst_n,
    output logic win_end
);
    logic [WIN_LOG2-1:0] cnt_q;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign win_end = &cnt_q;
endmodule

// File: rtl/lk_edge_meter.sv
module lk_edge_meter #(
    parameter int WIN_LOG2 = 12,
    parameter int PRE_DIV  = 128,
    parameter int RATIO_HI = 32,
    parameter int RATIO_LO = 8,
    parameter int TOL_PPM  = 500
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic rec_div_clk,
    input  logic rate_hi,
    input  logic win_end,
    output logic in_band
);
    localparam int WIN    = 1 << WIN_LOG2;
    localparam int EXP_HI = WIN * RATIO_HI / PRE_DIV;
    localparam int EXP_LO = WIN * RATIO_LO / PRE_DIV;
    localparam int TOL_HI = EXP_HI * TOL_PPM / 1000000 + 1;
    localparam int TOL_LO = EXP_LO * TOL_PPM / 1000000 + 1;
    localparam int CW     = WIN_LOG2 + 1;

    // [0],[1]: synchroniser, [2]: history for edge detect
    logic [2:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          rise;
    logic [CW-1:0] total, lo_b, hi_b;

    assign rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], rec_div_clk};
            if (win_end) cnt_q <= '0;
            else         cnt_q <= cnt_q + CW'(rise);
        end
    end

    always_comb begin
        total = cnt_q + CW'(rise);
        lo_b  = rate_hi ? CW'(EXP_HI - TOL_HI) : CW'(EXP_LO - TOL_LO);
        hi_b  = rate_hi ? CW'(EXP_HI + TOL_HI) : CW'(EXP_LO + TOL_LO);
        in_band = (total >= lo_b) && (total <= hi_b);
    end
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl
    import lk_pkg::*;
#(
    parameter int WIN_LOG2   = 12,
    parameter int PRE_DIV    = 128,
    parameter int RATIO_HI   = 32,
    parameter int RATIO_LO   = 8,
    parameter int TOL_PPM    = 500,
    parameter int TRAIN_WINS = 4
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic rec_div_clk,
    input  logic rate_hi,
    input  logic sig_det,
    input  logic lock_ref_n,
    input  logic test_en,
    output logic train_ref,
    output logic lock,
    output logic mute,
    output logic bad_cfg
);
    localparam int TCW = $clog2(TRAIN_WINS + 1);

    logic            win_end, in_band;
    logic            los, hold, bypass, tracking, locked_st;
    lk_state_e       state_q, state_d;
    logic [TCW-1:0]  tcnt_q;

    lk_win_timer #(.WIN_LOG2(WIN_LOG2)) timer_i (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    lk_edge_meter #(
        .WIN_LOG2 (WIN_LOG2),
        .PRE_DIV  (PRE_DIV),
        .RATIO_HI (RATIO_HI),
        .RATIO_LO (RATIO_LO),
        .TOL_PPM  (TOL_PPM)
    ) meter_i (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .rec_div_clk (rec_div_clk),
        .rate_hi     (rate_hi),
        .win_end     (win_end),
        .in_band     (in_band)
    );

    assign los    = ~sig_det | ~lock_ref_n;
    assign bypass = test_en & rate_hi;
    assign hold   = los | (test_en & ~rate_hi);

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRAIN;
        else        state_q <= state_d;
    end

    // training window counter
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)                                   tcnt_q <= '0;
        else if (state_q != ST_TRAIN || hold || bypass) tcnt_q <= '0;
        else if (win_end)                             tcnt_q <= tcnt_q + 1'b1;
    end

    // next state: bypass, then hold, then window verdict
    always_comb begin
        state_d = state_q;
        if (bypass) begin
            state_d = ST_BYPASS;
        end else if (hold || state_q == ST_BYPASS) begin
            state_d = ST_TRAIN;
        end else if (win_end) begin
            unique case (state_q)
                ST_TRAIN:  if (tcnt_q == TCW'(TRAIN_WINS - 1)) state_d = ST_TRACK0;
                ST_TRACK0: state_d = in_band ? ST_TRACK1 : ST_TRAIN;
                ST_TRACK1: state_d = in_band ? ST_LOCKED : ST_TRAIN;
                ST_LOCKED: state_d = in_band ? ST_LOCKED : ST_TRAIN;
                default:   state_d = ST_TRAIN;
            endcase
        end
    end

    // outputs
    always_comb begin
        tracking  = 1'b0;
        locked_st = 1'b0;
        unique case (state_q)
            ST_TRACK0, ST_TRACK1: tracking = 1'b1;
            ST_LOCKED: begin
                tracking  = 1'b1;
                locked_st = 1'b1;
            end
            default: ;
        endcase
        train_ref = ~tracking | hold | bypass;
        lock      = locked_st & ~hold & ~bypass;
        mute      = hold & ~bypass;
        bad_cfg   = test_en & ~rate_hi;
    end

    // R3: release only on the boundary that completes training
    a_r3_release_on_count: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_TRACK0 && $past(state_q) == ST_TRAIN)
            |-> ($past(win_end) && $past(tcnt_q) == TCW'(TRAIN_WINS - 1)));

    // R4: lock state is entered only from the one-good-window state at a boundary
    a_r4_lock_from_track1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_LOCKED && $past(state_q) != ST_LOCKED)
            |-> ($past(state_q) == ST_TRACK1 && $past(win_end)));

    // R5: leaving lock goes back to training (or bypass)
    a_r5_unlock_to_train: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(state_q) == ST_LOCKED && state_q != ST_LOCKED)
            |-> (state_q == ST_TRAIN || state_q == ST_BYPASS));

    // R6: loss of signal blocks lock and mutes data
    a_r6_los_mutes: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((!sig_det || !lock_ref_n) && !(test_en && rate_hi)) |-> (!lock && mute));

    // R7: bypass keeps the loop on the reference
    a_r7_bypass_ref: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (test_en && rate_hi) |=> (state_q == ST_BYPASS));

    // R8: illegal configuration is flagged and held
    a_r8_bad_cfg_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (test_en && !rate_hi) |=> (state_q == ST_TRAIN));
endmodule

// File: tb/freq_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module freq_lock_ctrl_tb_top;
    localparam int W  = 1024;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_clk = 1'b0;
    logic rate_hi = 1'b1, sig_det = 1'b1, lock_ref_n = 1'b1, test_en = 1'b0;
    logic train_ref, lock, mute, bad_cfg;
    int   rec_half = 10;

    int vectors = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // model state: 0 train, 1 released/no good, 2 released/one good, 3 locked, 4 bypass
    int k = 0;
    int mst = 0;
    int tcnt = 0;

    always #2.5 clk = ~clk;
    always begin
        #(rec_half);
        rec_clk = ~rec_clk;
    end

    freq_lock_ctrl #(.WIN_LOG2(10), .TRAIN_WINS(TW)) dut_i (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .rec_div_clk (rec_clk),
        .rate_hi     (rate_hi),
        .sig_det     (sig_det),
        .lock_ref_n  (lock_ref_n),
        .test_en     (test_en),
        .train_ref   (train_ref),
        .lock        (lock),
        .mute        (mute),
        .bad_cfg     (bad_cfg)
    );

    function automatic bit m_hold();
        return !sig_det || !lock_ref_n || (test_en && !rate_hi);
    endfunction
    function automatic bit m_byp();
        return test_en && rate_hi;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; mst = 0; tcnt = 0;
        end else begin
            bit good;
            good = rate_hi ? (rec_half == 10) : (rec_half == 40);
            if (m_byp()) begin
                mst = 4; tcnt = 0;
            end else if (m_hold() || mst == 4) begin
                mst = 0; tcnt = 0;
            end else if ((k % W) == W - 1) begin
                if (mst == 0) begin
                    if (tcnt == TW - 1) begin mst = 1; tcnt = 0; end
                    else tcnt = tcnt + 1;
                end else if (good) begin
                    mst = (mst >= 2) ? 3 : 2;
                end else begin
                    mst = 0; tcnt = 0;
                end
            end
            k = k + 1;
        end
    end

    task automatic check1(string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%b exp=%b at k=%0d", cur_req, what, act, exp, k);
        end
    endtask

    // compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit hb, bb;
            hb = m_hold(); bb = m_byp();
            check1("train_ref", train_ref, !(mst >= 1 && mst <= 3) || hb || bb);
            check1("lock", lock, (mst == 3) && !hb && !bb);
            check1("mute", mute, hb && !bb);
            check1("bad_cfg", bad_cfg, test_en && !rate_hi);
        end
    end

    task automatic bounds(input int n);
        repeat (n) begin
            @(negedge clk);
            while ((k % W) != 0) @(negedge clk);
        end
    endtask

    task automatic summary();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check1("reset train_ref", train_ref, 1'b1);
        check1("reset lock", lock, 1'b0);
        check1("reset mute", mute, 1'b0);
        rst_n = 1'b1;

        // R3 training length, R2 nominal high-rate count accepted, R4 two good windows
        cur_req = "R3";
        bounds(TW);
        check1("train released", train_ref, 1'b0);
        cur_req = "R4";
        bounds(1);
        check1("lock after one good", lock, 1'b0);
        bounds(1);
        check1("lock after two good", lock, 1'b1);

        // R5: out-of-band frequency, repeated training
        cur_req = "R5";
        rec_half = 9;
        bounds(1);
        check1("lock dropped", lock, 1'b0);
        check1("retrain", train_ref, 1'b1);
        bounds(TW);
        check1("released again", train_ref, 1'b0);
        bounds(1);
        check1("retrain repeats", train_ref, 1'b1);
        rec_half = 10;
        cur_req = "R2";
        bounds(TW + 2);
        check1("relock nominal", lock, 1'b1);

        // R6: loss of signal from either source
        cur_req = "R6";
        repeat (300) @(negedge clk);
        sig_det = 1'b0;
        #1;
        check1("sig_det low lock", lock, 1'b0);
        check1("sig_det low mute", mute, 1'b1);
        repeat (1500) @(negedge clk);
        sig_det = 1'b1;
        bounds(TW + 2);
        check1("relock after sig_det", lock, 1'b1);
        repeat (200) @(negedge clk);
        lock_ref_n = 1'b0;
        #1;
        check1("lock_ref_n low mute", mute, 1'b1);
        repeat (50) @(negedge clk);
        lock_ref_n = 1'b1;
        bounds(TW + 2);
        check1("relock after lock_ref_n", lock, 1'b1);

        // R10: loss of signal in the same cycle as a good window end
        cur_req = "R10";
        @(negedge clk);
        while ((k % W) != W - 1) @(negedge clk);
        sig_det = 1'b0;
        @(negedge clk);
        sig_det = 1'b1;
        check1("los wins over good window", lock, 1'b0);
        bounds(TW - 1);
        check1("still training", train_ref, 1'b1);
        bounds(1);
        check1("released after full count", train_ref, 1'b0);
        bounds(2);
        check1("relock", lock, 1'b1);

        // R9: low-rate mode
        cur_req = "R9";
        bounds(1);
        rate_hi = 1'b0;
        rec_half = 40;
        bounds(1);
        check1("low-rate stays locked", lock, 1'b1);
        rec_half = 35;
        bounds(1);
        check1("low-rate out of band", lock, 1'b0);
        rec_half = 40;
        bounds(TW + 2);
        check1("low-rate relock", lock, 1'b1);

        // R8: illegal configuration
        cur_req = "R8";
        repeat (100) @(negedge clk);
        test_en = 1'b1;
        #1;
        check1("bad_cfg flag", bad_cfg, 1'b1);
        check1("bad_cfg mute", mute, 1'b1);
        check1("bad_cfg lock", lock, 1'b0);
        repeat (100) @(negedge clk);
        test_en = 1'b0;
        bounds(TW + 2);
        check1("relock after bad_cfg", lock, 1'b1);

        // R7: bypass ignores loss of signal
        cur_req = "R7";
        repeat (100) @(negedge clk);
        rate_hi = 1'b1;
        rec_half = 10;
        test_en = 1'b1;
        sig_det = 1'b0;
        #1;
        check1("bypass mute", mute, 1'b0);
        check1("bypass train_ref", train_ref, 1'b1);
        check1("bypass lock", lock, 1'b0);
        check1("bypass bad_cfg", bad_cfg, 1'b0);
        repeat (200) @(negedge clk);
        sig_det = 1'b1;
        test_en = 1'b0;
        bounds(TW + 2);
        check1("relock after bypass", lock, 1'b1);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule